// File: doc/BRIEF.md
# Programmable Color Space Matrix Converter

This block converts a stream of pixels between two three-component color spaces, such as luma/chroma and red/green/blue, at one pixel per clock. Each color sample first receives a programmable input offset. The three offset-corrected samples then go through a fully programmable 3x3 matrix multiply. The products and their sums are kept at full precision. A programmable output offset is added next. The result is rounded once, to either 10-bit or 8-bit precision, and then saturated into a selectable output range. A fourth channel carries a key (alpha) sample. It has its own scale coefficient and is not touched by the matrix.

A byte-wide register write port loads the ten coefficients, the six offsets and the mode word. A 13-bit coefficient is written as two bytes. The new value takes effect only when the upper byte arrives, so the datapath never uses a half-written coefficient. A bypass mode passes every channel through unchanged, with the same latency as the matrix path. Color samples are unsigned 13-bit words that hold 10-bit video in their upper ten bits.

Top module: `csc_matrix_top`

## Requirements
- R1: After reset, `pix_vld_o` and all sample outputs are zero. The configuration comes up as follows: identity matrix, key coefficient 1.0, all offsets zero, bypass off, clip selector 0, 10-bit rounding.
- R2: Each valid input pixel gives exactly one valid output pixel. The output appears 4 clocks later (input sampled at edge N, output visible after edge N+3), and pixels keep their order.
- R3: Output channel r is the sum over c of coef[3r+c] × (in_c + input offset c), plus the output offset r. The coefficients are signed two's complement Q2.11, so 1.0 is 0x0800. Coefficient k is written at address 2k (bits 7:0) and then at address 2k+1 (bits 4:0 give coefficient bits 12:8), for k = 0..8.
- R4: The nine products and the three sums are exact. Rounding happens once, on the final sum.
- R5: Input offsets sit at addresses 20..22 and output offsets at 23..25, one per channel. Each is an 8-bit signed value weighted by 32 output LSBs.
- R6: The key output is the key input times the key coefficient (addresses 18/19, Q2.11), rounded half up to an integer and saturated to 0..2047.
- R7: Mode bit 0 (address 26) selects bypass. In bypass, all four outputs equal the inputs bit for bit, with the same latency as R2.
- R8: Mode bits 2:1 hold the clip selector s. Color results saturate to the range 0..2^(13−s)−1 and never wrap.
- R9: Mode bit 3 = 1 rounds to 10-bit precision (the low 3 bits of the result are zero). Mode bit 3 = 0 rounds to 8-bit precision (the low 5 bits are zero). Both round half up, and rounding is applied before clipping.
- R10: A lower-byte coefficient write alone does not change any output. The coefficient changes only on the following upper-byte write.
- R11: Writes to addresses 27..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_c0_i | input | 13 | Color channel 0 in |
| pix_c1_i | input | 13 | Color channel 1 in |
| pix_c2_i | input | 13 | Color channel 2 in |
| pix_key_i | input | 11 | Key channel in |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_c0_o | output | 13 | Color channel 0 out |
| pix_c1_o | output | 13 | Color channel 1 out |
| pix_c2_o | output | 13 | Color channel 2 out |
| pix_key_o | output | 11 | Key channel out |

## Verification
A luma/chroma-to-RGB matrix with negative chroma offsets is driven with pseudo-random video. This tests signed coefficients, cross-channel terms and saturation at both ends together. A channel permutation shows that every coefficient reaches the correct row and column. Near-one-third coefficients on odd inputs separate a single final rounding from rounding each product.

Ramps around the rounding thresholds, run under every clip selector and both precisions, separate round-half-up from truncation and saturation from wrap-around. A lower-byte-only coefficient write, followed by a pixel, shows whether the datapath ever sees a half-loaded coefficient.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int CW      = 13;            // color sample width
    localparam int KW      = 11;            // key sample width
    localparam int CFW     = 13;            // coefficient width
    localparam int FRAC    = 11;            // coefficient fraction bits
    localparam int NCH     = 3;             // color channels
    localparam int NCOEF   = NCH * NCH;     // matrix coefficients
    localparam int NCF     = NCOEF + 1;     // plus the key coefficient
    localparam int AW      = 5;             // register address width
    localparam int DW      = 8;             // register data width
    localparam int OFSW    = 8;             // offset register width
    localparam int OFS_SH  = 5;             // offset weight as a left shift
    localparam int LAT     = 4;             // pipeline depth
    localparam int PREC_HI = 10;            // fine rounding precision
    localparam int PREC_LO = 8;             // coarse rounding precision

    localparam int IW      = CW + 2;        // offset-adjusted sample
    localparam int PW      = IW + CFW;      // one product
    localparam int SW      = PW + 2;        // sum of three products plus offset
    localparam int KPW     = KW + 1 + CFW;  // key product
    localparam int HI_BITS = CFW - DW;      // bits carried by the upper byte

    localparam logic [AW-1:0]  ADDR_OFS_IN  = AW'(2 * NCF);
    localparam logic [AW-1:0]  ADDR_OFS_OUT = AW'(2 * NCF + NCH);
    localparam logic [AW-1:0]  ADDR_MODE    = AW'(2 * NCF + 2 * NCH);
    localparam logic [CFW-1:0] COEF_ONE     = CFW'(1) << FRAC;

    typedef struct packed {
        logic       rnd10;      // bit 3
        logic [1:0] clip_sel;   // bits 2:1
        logic       bypass;     // bit 0
    } mode_t;

    typedef logic [NCF-1:0][CFW-1:0]  coef_arr_t;
    typedef logic [NCH-1:0][OFSW-1:0] ofs_arr_t;
    typedef logic [NCH-1:0][CW-1:0]   chan_arr_t;
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
    import csc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output coef_arr_t       coef_o,
    output ofs_arr_t        ofs_in_o,
    output ofs_arr_t        ofs_out_o,
    output mode_t           mode_o
);
    typedef struct packed {
        logic [DW-1:0] lo;      // staged lower coefficient byte
        coef_arr_t     cf;
        ofs_arr_t      oi;
        ofs_arr_t      oo;
        mode_t         md;
    } regs_t;

    function automatic regs_t reset_val();
        regs_t r;
        r = '0;
        for (int i = 0; i < NCH; i++) begin
            r.cf[i * NCH + i] = COEF_ONE;
        end
        r.cf[NCOEF] = COEF_ONE;
        r.md.rnd10  = 1'b1;
        return r;
    endfunction

    localparam regs_t RST_VAL = reset_val();

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if ((wr_addr < ADDR_OFS_IN) && !wr_addr[0]) begin
                r_d.lo = wr_data;
            end
            for (int i = 0; i < NCF; i++) begin
                if (wr_addr == AW'(2 * i + 1)) begin
                    r_d.cf[i] = {wr_data[HI_BITS-1:0], r_q.lo};
                end
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == ADDR_OFS_IN + AW'(i)) begin
                    r_d.oi[i] = wr_data;
                end
                if (wr_addr == ADDR_OFS_OUT + AW'(i)) begin
                    r_d.oo[i] = wr_data;
                end
            end
            if (wr_addr == ADDR_MODE) begin
                r_d.md = mode_t'(wr_data[$bits(mode_t)-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign coef_o    = r_q.cf;
    assign ofs_in_o  = r_q.oi;
    assign ofs_out_o = r_q.oo;
    assign mode_o    = r_q.md;
endmodule

// File: rtl/csc_round_clip.sv
module csc_round_clip
    import csc_pkg::*;
(
    input  logic signed [SW-1:0] acc_i,
    input  logic                 rnd10_i,
    input  logic [1:0]           clip_sel_i,
    output logic [CW-1:0]        res_o
);
    localparam int RB_FINE   = CW - PREC_HI;
    localparam int RB_COARSE = CW - PREC_LO;

    int                 rb;
    logic signed [SW-1:0] half;
    logic signed [SW-1:0] quot;
    logic signed [SW-1:0] val;
    logic signed [SW-1:0] vmax;

    always_comb begin
        rb   = rnd10_i ? RB_FINE : RB_COARSE;
        half = SW'(1) <<< (FRAC + rb - 1);
        quot = (acc_i + half) >>> (FRAC + rb);
        val  = quot <<< rb;
        vmax = (SW'(1) <<< (CW - int'(clip_sel_i))) - SW'(1);
        if (val < 0) begin
            res_o = '0;
        end else if (val > vmax) begin
            res_o = CW'(vmax);
        end else begin
            res_o = CW'(val);
        end
    end
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
    import csc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld_i,
    input  chan_arr_t       in_c_i,
    input  logic [KW-1:0]   in_key_i,
    input  coef_arr_t       coef_i,
    input  ofs_arr_t        ofs_in_i,
    input  ofs_arr_t        ofs_out_i,
    input  mode_t           mode_i,
    output logic            out_vld_o,
    output chan_arr_t       out_c_o,
    output logic [KW-1:0]   out_key_o
);
    localparam logic signed [KPW-1:0] KMAX = KPW'((1 << KW) - 1);

    typedef struct packed {
        logic [LAT-1:0]                  vld;
        logic [NCH-1:0][IW-1:0]          adj;    // stage 1
        logic [KW-1:0]                   key1;
        logic [NCOEF-1:0][PW-1:0]        prod;   // stage 2
        logic [KPW-1:0]                  kprod2;
        logic [NCH-1:0][SW-1:0]          acc;    // stage 3
        logic [KPW-1:0]                  kprod3;
        logic [LAT-2:0][NCH-1:0][CW-1:0] raw_c;  // bypass delay line
        logic [LAT-2:0][KW-1:0]          raw_k;
        chan_arr_t                       out_c;  // stage 4
        logic [KW-1:0]                   out_k;
    } pipe_t;

    pipe_t p_d, p_q;

    chan_arr_t                rc_res;
    logic [KW-1:0]            key_res;
    logic signed [KPW-1:0]    kround;
    logic signed [SW-1:0]     sum_tmp;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_rc
        csc_round_clip u_rc (
            .acc_i      ($signed(p_q.acc[ch])),
            .rnd10_i    (mode_i.rnd10),
            .clip_sel_i (mode_i.clip_sel),
            .res_o      (rc_res[ch])
        );
    end

    always_comb begin
        kround = $signed(p_q.kprod3) + (KPW'(1) <<< (FRAC - 1));
        kround = kround >>> FRAC;
        if (kround < 0) begin
            key_res = '0;
        end else if (kround > KMAX) begin
            key_res = '1;
        end else begin
            key_res = KW'(kround);
        end
    end

    always_comb begin
        p_d     = p_q;
        sum_tmp = '0;
        p_d.vld = {p_q.vld[LAT-2:0], in_vld_i};

        for (int ch = 0; ch < NCH; ch++) begin
            p_d.adj[ch] = IW'($signed({2'b00, in_c_i[ch]}))
                        + (IW'($signed(ofs_in_i[ch])) <<< OFS_SH);
        end
        p_d.key1 = in_key_i;

        for (int r = 0; r < NCH; r++) begin
            for (int c = 0; c < NCH; c++) begin
                p_d.prod[r * NCH + c] = PW'($signed(p_q.adj[c]))
                                      * PW'($signed(coef_i[r * NCH + c]));
            end
        end
        p_d.kprod2 = KPW'($signed({1'b0, p_q.key1})) * KPW'($signed(coef_i[NCOEF]));

        for (int r = 0; r < NCH; r++) begin
            sum_tmp = SW'($signed(ofs_out_i[r])) <<< (OFS_SH + FRAC);
            for (int c = 0; c < NCH; c++) begin
                sum_tmp = sum_tmp + SW'($signed(p_q.prod[r * NCH + c]));
            end
            p_d.acc[r] = sum_tmp;
        end
        p_d.kprod3 = p_q.kprod2;

        p_d.raw_c = {p_q.raw_c[LAT-3:0], in_c_i};
        p_d.raw_k = {p_q.raw_k[LAT-3:0], in_key_i};

        if (mode_i.bypass) begin
            p_d.out_c = p_q.raw_c[LAT-2];
            p_d.out_k = p_q.raw_k[LAT-2];
        end else begin
            p_d.out_c = rc_res;
            p_d.out_k = key_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_vld_o = p_q.vld[LAT-1];
    assign out_c_o   = p_q.out_c;
    assign out_key_o = p_q.out_k;
endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
    import csc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            pix_vld_i,
    input  logic [CW-1:0]   pix_c0_i,
    input  logic [CW-1:0]   pix_c1_i,
    input  logic [CW-1:0]   pix_c2_i,
    input  logic [KW-1:0]   pix_key_i,
    output logic            pix_vld_o,
    output logic [CW-1:0]   pix_c0_o,
    output logic [CW-1:0]   pix_c1_o,
    output logic [CW-1:0]   pix_c2_o,
    output logic [KW-1:0]   pix_key_o
);
    coef_arr_t coef_w;
    ofs_arr_t  ofs_in_w;
    ofs_arr_t  ofs_out_w;
    mode_t     mode_w;
    chan_arr_t in_c_w;
    chan_arr_t out_c_w;

    assign in_c_w = {pix_c2_i, pix_c1_i, pix_c0_i};

    csc_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .coef_o    (coef_w),
        .ofs_in_o  (ofs_in_w),
        .ofs_out_o (ofs_out_w),
        .mode_o    (mode_w)
    );

    csc_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld_i  (pix_vld_i),
        .in_c_i    (in_c_w),
        .in_key_i  (pix_key_i),
        .coef_i    (coef_w),
        .ofs_in_i  (ofs_in_w),
        .ofs_out_i (ofs_out_w),
        .mode_i    (mode_w),
        .out_vld_o (pix_vld_o),
        .out_c_o   (out_c_w),
        .out_key_o (pix_key_o)
    );

    assign pix_c0_o = out_c_w[0];
    assign pix_c1_o = out_c_w[1];
    assign pix_c2_o = out_c_w[2];
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
    import csc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic          pix_vld_i,
    input  chan_arr_t     in_c,
    input  logic          pix_vld_o,
    input  chan_arr_t     out_c,
    input  coef_arr_t     coef,
    input  ofs_arr_t      ofs_in,
    input  ofs_arr_t      ofs_out,
    input  mode_t         mode
);
    logic [2:0] since_rst;
    mode_t      mode_prev;
    logic       steady;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            mode_prev <= '0;
        end else begin
            since_rst <= (since_rst == 3'(LAT)) ? since_rst : since_rst + 3'd1;
            mode_prev <= mode;
        end
    end

    assign steady = (since_rst == 3'(LAT)) && (mode == mode_prev);

    function automatic logic [CW-1:0] top_of(logic [1:0] s);
        return CW'((1 << (CW - int'(s))) - 1);
    endfunction

    function automatic logic grid_ok(logic [CW-1:0] v, logic r10, logic [1:0] s);
        logic [CW-1:0] m;
        m = CW'((1 << (r10 ? (CW - PREC_HI) : (CW - PREC_LO))) - 1);
        return (v == top_of(s)) || ((v & m) == '0);
    endfunction

    // R2: valid emerges exactly LAT cycles after entry
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(LAT)) |-> (pix_vld_o == $past(pix_vld_i, LAT)));

    // R7: bypass returns the sample that entered LAT cycles earlier
    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && pix_vld_o && mode_prev.bypass) |-> (out_c == $past(in_c, LAT)));

    // R8: results never exceed the selected range top
    assert_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && pix_vld_o && !mode_prev.bypass) |->
        ((out_c[0] <= top_of(mode_prev.clip_sel)) &&
         (out_c[1] <= top_of(mode_prev.clip_sel)) &&
         (out_c[2] <= top_of(mode_prev.clip_sel))));

    // R9: results lie on the selected rounding grid unless saturated high
    assert_round_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && pix_vld_o && !mode_prev.bypass) |->
        (grid_ok(out_c[0], mode_prev.rnd10, mode_prev.clip_sel) &&
         grid_ok(out_c[1], mode_prev.rnd10, mode_prev.clip_sel) &&
         grid_ok(out_c[2], mode_prev.rnd10, mode_prev.clip_sel)));

    // R10: a lower-byte write leaves every coefficient untouched
    assert_half_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr < ADDR_OFS_IN) && !cfg_addr[0]) |=> $stable(coef));

    // R11: unused addresses alter no configuration
    assert_unused_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr > ADDR_MODE)) |=>
        ($stable(coef) && $stable(ofs_in) && $stable(ofs_out) && $stable(mode)));
endmodule

bind csc_matrix_top csc_matrix_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .pix_vld_i (pix_vld_i),
    .in_c      (in_c_w),
    .pix_vld_o (pix_vld_o),
    .out_c     (out_c_w),
    .coef      (coef_w),
    .ofs_in    (ofs_in_w),
    .ofs_out   (ofs_out_w),
    .mode      (mode_w)
);

// File: tb/sim_csc_matrix_top.sv
`timescale 1ns/1ps
module sim_csc_matrix_top;
    localparam int LATENCY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        pix_vld_i = 1'b0;
    logic [12:0] pix_c0_i = '0, pix_c1_i = '0, pix_c2_i = '0;
    logic [10:0] pix_key_i = '0;
    logic        pix_vld_o;
    logic [12:0] pix_c0_o, pix_c1_o, pix_c2_o;
    logic [10:0] pix_key_o;

    csc_matrix_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_vld_i(pix_vld_i), .pix_c0_i(pix_c0_i),
        .pix_c1_i(pix_c1_i), .pix_c2_i(pix_c2_i), .pix_key_i(pix_key_i),
        .pix_vld_o(pix_vld_o), .pix_c0_o(pix_c0_o), .pix_c1_o(pix_c1_o),
        .pix_c2_o(pix_c2_o), .pix_key_o(pix_key_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;
    int unsigned seed = 32'h1234_5678;

    // bench copy of the configuration, kept from the requirements
    longint bc[10];
    longint bo_in[3];
    longint bo_out[3];
    bit     b_byp;
    int     b_clip;
    bit     b_r10;

    typedef struct {
        int    c0, c1, c2, k, due;
        string tag;
    } exp_t;
    exp_t expq[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(int range);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % range);
    endfunction

    function automatic int model_ch(int r, int i0, int i1, int i2);
        longint a[3];
        longint acc, q, v, mx;
        int rb;
        a[0] = i0 + bo_in[0] * 32;
        a[1] = i1 + bo_in[1] * 32;
        a[2] = i2 + bo_in[2] * 32;
        acc = bo_out[r] * 32 * 2048;
        for (int c = 0; c < 3; c++) acc += bc[r * 3 + c] * a[c];
        rb = b_r10 ? 3 : 5;
        q = (acc + (longint'(1) << (10 + rb))) >>> (11 + rb);
        v = q <<< rb;
        mx = (longint'(1) << (13 - b_clip)) - 1;
        if (v < 0) v = 0;
        if (v > mx) v = mx;
        return int'(v);
    endfunction

    function automatic int model_key(int k);
        longint q;
        q = (longint'(k) * bc[9] + 1024) >>> 11;
        if (q < 0) q = 0;
        if (q > 2047) q = 2047;
        return int'(q);
    endfunction

    always @(negedge clk) begin
        if (rst_n && pix_vld_o) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2", "unexpected output pixel", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (cyc != e.due)
                    chk(1'b0, "R2", {e.tag, " output cycle"}, cyc, e.due);
                else if (pix_c0_o != 13'(e.c0))
                    chk(1'b0, e.tag, "channel 0", pix_c0_o, e.c0);
                else if (pix_c1_o != 13'(e.c1))
                    chk(1'b0, e.tag, "channel 1", pix_c1_o, e.c1);
                else if (pix_c2_o != 13'(e.c2))
                    chk(1'b0, e.tag, "channel 2", pix_c2_o, e.c2);
                else if (pix_key_o != 11'(e.k))
                    chk(1'b0, e.tag, "key", pix_key_o, e.k);
                else
                    chk(1'b1, e.tag, "", 0, 0);
            end
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_coef(int idx, longint v);
        logic [12:0] bits;
        bits = 13'(v);
        wr(2 * idx, int'(bits[7:0]));
        wr(2 * idx + 1, int'(bits[12:8]));
        bc[idx] = v;
    endtask

    task automatic set_matrix(longint m0, longint m1, longint m2, longint m3, longint m4,
                              longint m5, longint m6, longint m7, longint m8);
        set_coef(0, m0); set_coef(1, m1); set_coef(2, m2);
        set_coef(3, m3); set_coef(4, m4); set_coef(5, m5);
        set_coef(6, m6); set_coef(7, m7); set_coef(8, m8);
    endtask

    task automatic set_ofs(bit outp, int ch, int v);
        wr((outp ? 23 : 20) + ch, v & 8'hFF);
        if (outp) bo_out[ch] = v; else bo_in[ch] = v;
    endtask

    task automatic set_mode(bit byp, int clip, bit r10);
        wr(26, (int'(r10) << 3) | (clip << 1) | int'(byp));
        b_byp = byp; b_clip = clip; b_r10 = r10;
    endtask

    task automatic send(int c0, int c1, int c2, int k, string tag);
        exp_t e;
        @(negedge clk);
        pix_vld_i = 1'b1;
        pix_c0_i = 13'(c0); pix_c1_i = 13'(c1); pix_c2_i = 13'(c2); pix_key_i = 11'(k);
        if (b_byp) begin
            e.c0 = c0; e.c1 = c1; e.c2 = c2; e.k = k;
        end else begin
            e.c0 = model_ch(0, c0, c1, c2);
            e.c1 = model_ch(1, c0, c1, c2);
            e.c2 = model_ch(2, c0, c1, c2);
            e.k  = model_key(k);
        end
        e.due = cyc + LATENCY;
        e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic drain();
        @(negedge clk);
        pix_vld_i = 1'b0;
        repeat (LATENCY + 2) @(negedge clk);
    endtask

    task automatic defaults_shadow();
        for (int i = 0; i < 10; i++) bc[i] = 0;
        bc[0] = 2048; bc[4] = 2048; bc[8] = 2048; bc[9] = 2048;
        for (int i = 0; i < 3; i++) begin bo_in[i] = 0; bo_out[i] = 0; end
        b_byp = 1'b0; b_clip = 0; b_r10 = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pix_vld_o == 1'b0, "R1", "valid during reset", pix_vld_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pix_vld_o == 1'b0, "R1", "valid after reset", pix_vld_o, 0);
        chk({pix_c0_o, pix_c1_o, pix_c2_o, pix_key_o} == '0, "R1", "outputs after reset",
            {pix_c0_o, pix_c1_o, pix_c2_o, pix_key_o}, 0);
        send(1000, 1005, 8191, 2047, "R1");
        send(0, 4, 3, 1, "R1");
        drain();
    endtask

    task automatic t_matrix();
        // luma/chroma to RGB, chroma centred by input offsets
        set_matrix(2048, 0, 2871, 2048, -705, -1462, 2048, 3629, 0);
        set_ofs(1'b0, 1, -128);
        set_ofs(1'b0, 2, -128);
        for (int i = 0; i < 12; i++)
            send(512 + rnd(7009), 512 + rnd(7169), 512 + rnd(7169), rnd(2048), "R3");
        drain();
        // channel permutation
        set_ofs(1'b0, 1, 0);
        set_ofs(1'b0, 2, 0);
        set_matrix(0, 0, 2048, 2048, 0, 0, 0, 2048, 0);
        send(800, 1600, 2400, 5, "R3");
        send(8, 4000, 7999, 6, "R3");
        drain();
        // near one third weights: one final rounding only
        set_matrix(683, 683, 682, 683, 682, 683, 682, 683, 683);
        send(1001, 2003, 3005, 7, "R4");
        send(13, 27, 41, 9, "R4");
        send(8191, 8191, 8191, 11, "R4");
        drain();
    endtask

    task automatic t_offsets();
        set_matrix(2048, 0, 0, 0, 2048, 0, 0, 0, 2048);
        set_ofs(1'b0, 0, 10);
        set_ofs(1'b0, 1, -3);
        set_ofs(1'b1, 1, 5);
        set_ofs(1'b1, 2, -128);
        send(1000, 2000, 3000, 0, "R5");
        send(0, 50, 5000, 0, "R5");
        send(8000, 8191, 4096, 0, "R5");
        drain();
        for (int i = 0; i < 3; i++) begin
            set_ofs(1'b0, i, 0);
            set_ofs(1'b1, i, 0);
        end
    endtask

    task automatic t_key();
        longint kc[5] = '{2048, 1024, 4095, -2048, 341};
        for (int j = 0; j < 5; j++) begin
            set_coef(9, kc[j]);
            send(100, 200, 300, 0, "R6");
            send(100, 200, 300, 1, "R6");
            send(100, 200, 300, 1023, "R6");
            send(100, 200, 300, 2047, "R6");
            drain();
        end
        set_coef(9, 2048);
    endtask

    task automatic t_bypass();
        set_matrix(1000, -500, 300, 4000, 7, -4096, 0, 1, 2);
        set_mode(1'b1, 3, 1'b0);
        send(8191, 1, 4097, 2047, "R7");
        send(7, 5003, 33, 1, "R7");
        send(0, 8190, 1234, 555, "R7");
        drain();
        set_mode(1'b0, 0, 1'b1);
    endtask

    task automatic t_clip();
        set_matrix(3891, 0, 0, 0, 3891, 0, -2048, 0, 0);
        for (int s = 0; s < 4; s++) begin
            set_mode(1'b0, s, 1'b1);
            send(0, 0, 0, 0, "R8");
            send(500, 500, 500, 0, "R8");
            send(2000, 2000, 2000, 0, "R8");
            send(4500, 4500, 4500, 0, "R8");
            send(8191, 8191, 8191, 0, "R8");
            drain();
        end
        set_mode(1'b0, 0, 1'b1);
    endtask

    task automatic t_round();
        set_matrix(2048, 0, 0, 0, 2048, 0, 0, 0, 2048);
        for (int r = 0; r < 2; r++) begin
            set_mode(1'b0, 0, r[0]);
            send(15, 16, 17, 0, "R9");
            send(3, 4, 5, 0, "R9");
            send(47, 48, 49, 0, "R9");
            send(1023, 8180, 8191, 0, "R9");
            drain();
        end
        set_mode(1'b0, 0, 1'b1);
    endtask

    task automatic t_atomic();
        // identity loaded; stage only the lower byte of coefficient 0
        wr(0, 8'h55);
        send(1000, 2000, 3000, 0, "R10");
        drain();
        wr(1, 8'h05);
        bc[0] = 13'h0555;
        send(1000, 2000, 3000, 0, "R10");
        drain();
        set_coef(0, 2048);
    endtask

    task automatic t_ignore();
        for (int a = 27; a < 32; a++) wr(a, 8'hFF);
        send(1000, 2000, 3000, 1500, "R11");
        send(8191, 1, 64, 7, "R11");
        drain();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            chk(1'b0, "R2", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        defaults_shadow();
        repeat (5) @(negedge clk);
        t_reset();
        t_matrix();
        t_offsets();
        t_key();
        t_bypass();
        t_clip();
        t_round();
        t_atomic();
        t_ignore();
        drain();
        chk(expq.size() == 0, "R2", "pixels never emitted", expq.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule